// File: doc/BRIEF.md
# Phase/Frequency Comparator with Lock Qualifier

This block sits between the two programmable dividers of a frequency synthesizer and the analog charge pump. It samples the divided reference pulse and the divided feedback pulse on a fast sampling clock. A three-state phase/frequency state machine turns the order of their rising edges into pump-up or pump-down requests. Two independent tristate drive codes carry those requests: one feeds a passive loop filter and one feeds an active loop filter. A pump output rests at high impedance whenever no correction is being applied.

A run input marks that the core supply is up. When run is low the block is in standby. Both drive codes float at once, the comparator is held in its idle state, and divider edges are ignored.

A lock qualifier measures every pump pulse in sampling clocks. It raises its lock output only after a configured number of consecutive compare cycles have all stayed within a configured width limit. It pulls the lock output low as soon as one pulse exceeds that limit. The lock output is low while the loop is unlocked.

Comparator states: PH_IDLE (no pump), PH_UP (pump up), PH_DN (pump down). Its transitions are:
- PH_IDLE to PH_UP on a lone reference edge.
- PH_IDLE to PH_DN on a lone feedback edge.
- PH_UP to PH_IDLE on a feedback edge.
- PH_DN to PH_IDLE on a reference edge.
- PH_IDLE to PH_IDLE on coincident edges.
- Any state to PH_IDLE while run is low.

Lock qualifier states: LK_UNLOCKED and LK_LOCKED. Its transitions are:
- LK_UNLOCKED to LK_LOCKED when the consecutive count of good cycles reaches LOCK_CYCLES.
- Any state to LK_UNLOCKED on an over-long pulse or while run is low.

Top module: `phase_lock_cmp`

## Requirements
- R1: After reset the comparator is in PH_IDLE, both drive codes read oe=0 and lvl=0, and locked is 0.
- R2: Each drive code is a pair (oe, lvl). oe=1,lvl=1 means pump up, oe=1,lvl=0 means pump down, and oe=0,lvl=0 means high impedance. The passive-filter and active-filter codes always carry the same request. A reference rising edge that is sampled in PH_IDLE without a feedback edge gives pump up from the next clock onward.
- R3: A feedback rising edge that is sampled in PH_IDLE without a reference edge gives pump down from the next clock onward.
- R4: In PH_UP a feedback edge returns both codes to high impedance on the next clock. In PH_DN a reference edge does the same. A repeat of the leading edge leaves the pump running.
- R5: Reference and feedback edges sampled in the same clock while in PH_IDLE leave both codes at high impedance. They count as one compare cycle of zero width.
- R6: While run is 0, both codes read oe=0 in that same cycle, the comparator returns to PH_IDLE, and edges are ignored. An input that is already high when run returns is not taken as an edge.
- R7: locked goes to 1 on the clock that ends the LOCK_CYCLES-th consecutive compare cycle whose pump pulse lasted at most WIDTH_LIMIT clocks. It is still 0 after LOCK_CYCLES-1 such cycles.
- R8: A pump pulse that lasts exactly WIDTH_LIMIT clocks keeps the lock. A pulse still on after WIDTH_LIMIT clocks sets locked to 0 one clock later, while the pump itself keeps running.
- R9: A compare cycle with an over-long pulse restarts the count, so LOCK_CYCLES further good cycles are needed before locked returns to 1.
- R10: Run going to 0 clears locked and the good-cycle count.
- R11: Only a 0-to-1 change between consecutive samples of an input counts as an edge. A level that stays high does not trigger again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Core power enable; 0 selects standby |
| ref_pulse | input | 1 | Divided reference pulse |
| fb_pulse | input | 1 | Divided feedback pulse |
| pas_oe | output | 1 | Passive-filter drive enable (0 = high impedance) |
| pas_lvl | output | 1 | Passive-filter drive level (1 = up, 0 = down) |
| act_oe | output | 1 | Active-filter drive enable (0 = high impedance) |
| act_lvl | output | 1 | Active-filter drive level (1 = up, 0 = down) |
| locked | output | 1 | Lock flag, low while unlocked |

## Verification
The hardest situation to reach from the ports is the edge of the width limit while the loop is already locked. The design must tell apart a pulse of exactly WIDTH_LIMIT clocks from one of WIDTH_LIMIT+1 clocks, and then require a full recount before lock returns. The stimulus first builds a lock from zero-width compare cycles made by coincident edges. It then opens a pump with a lone reference edge and places the feedback edge at a counted clock. The lock output is sampled on the clock before and on the clock after it is expected to fall. A stimulus table covers the edge-ordering and standby paths, including inputs that are held high across a standby period.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_UP   = 2'd1,
        PH_DN   = 2'd2
    } ph_state_e;

    typedef enum logic {
        LK_UNLOCKED = 1'b0,
        LK_LOCKED   = 1'b1
    } lk_state_e;

    typedef struct packed {
        logic oe;
        logic lvl;
    } drive_t;

    localparam int unsigned NUM_DRIVES = 2;
    localparam int unsigned PAS_IDX    = 0;
    localparam int unsigned ACT_IDX    = 1;

endpackage

// File: rtl/pfd_edge_rise.sv
module pfd_edge_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic prev_q;

    // history follows the input at all times, standby included
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= din;
        end
    end

    assign rise = din & ~prev_q;

endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      ref_rise,
    input  logic      fb_rise,
    output ph_state_e state,
    output logic      cyc_end
);

    ph_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state decision
    always_comb begin
        nxt = state;
        if (!run) begin
            nxt = PH_IDLE;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    if (ref_rise && !fb_rise) begin
                        nxt = PH_UP;
                    end else if (fb_rise && !ref_rise) begin
                        nxt = PH_DN;
                    end
                end
                PH_UP: begin
                    if (fb_rise) begin
                        nxt = PH_IDLE;
                    end
                end
                PH_DN: begin
                    if (ref_rise) begin
                        nxt = PH_IDLE;
                    end
                end
                default: nxt = PH_IDLE;
            endcase
        end
    end

    // a compare cycle closes when a pump stops or both edges coincide
    always_comb begin
        cyc_end = 1'b0;
        if (run) begin
            if (state != PH_IDLE && nxt == PH_IDLE) begin
                cyc_end = 1'b1;
            end else if (state == PH_IDLE && ref_rise && fb_rise) begin
                cyc_end = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pfd_width_timer.sv
module pfd_width_timer
    import pfd_pkg::*;
#(
    parameter int unsigned WIDTH_LIMIT = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  ph_state_e state,
    output logic      too_long
);

    localparam int unsigned CW = $clog2(WIDTH_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(WIDTH_LIMIT);

    logic [CW-1:0] wcnt_q;

    // counts completed clocks spent pumping, saturating at the limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (state == PH_IDLE) begin
            wcnt_q <= '0;
        end else if (wcnt_q < LIM) begin
            wcnt_q <= wcnt_q + 1'b1;
        end
    end

    assign too_long = (state != PH_IDLE) && (wcnt_q >= LIM);

endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual
    import pfd_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cyc_end,
    input  logic too_long,
    output logic locked
);

    localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] TARGET = CW'(LOCK_CYCLES);
    localparam logic [CW-1:0] LAST   = CW'(LOCK_CYCLES - 1);

    lk_state_e     lk_q, lk_nxt;
    logic [CW-1:0] cnt_q, cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q  <= LK_UNLOCKED;
            cnt_q <= '0;
        end else begin
            lk_q  <= lk_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // transitions
    always_comb begin
        lk_nxt  = lk_q;
        cnt_nxt = cnt_q;
        if (!run || too_long) begin
            lk_nxt  = LK_UNLOCKED;
            cnt_nxt = '0;
        end else if (cyc_end) begin
            unique case (lk_q)
                LK_UNLOCKED: begin
                    if (cnt_q >= LAST) begin
                        lk_nxt  = LK_LOCKED;
                        cnt_nxt = TARGET;
                    end else begin
                        cnt_nxt = cnt_q + 1'b1;
                    end
                end
                LK_LOCKED: begin
                    cnt_nxt = TARGET;
                end
                default: begin
                    lk_nxt  = LK_UNLOCKED;
                    cnt_nxt = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        locked = (lk_q == LK_LOCKED);
    end

endmodule

// File: rtl/pfd_pump_drive.sv
module pfd_pump_drive
    import pfd_pkg::*;
(
    input  logic      run,
    input  ph_state_e state,
    output drive_t    drv
);

    always_comb begin
        drv = '0;
        unique case (state)
            PH_UP:   drv = '{oe: run, lvl: run};
            PH_DN:   drv = '{oe: run, lvl: 1'b0};
            default: drv = '0;
        endcase
    end

endmodule

// File: rtl/phase_lock_cmp.sv
module phase_lock_cmp
    import pfd_pkg::*;
#(
    parameter int unsigned WIDTH_LIMIT = 8,
    parameter int unsigned LOCK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_pulse,
    input  logic fb_pulse,
    output logic pas_oe,
    output logic pas_lvl,
    output logic act_oe,
    output logic act_lvl,
    output logic locked
);

    logic      ref_rise;
    logic      fb_rise;
    ph_state_e ph_state;
    logic      cyc_end;
    logic      too_long;
    drive_t    drv_q [NUM_DRIVES];

    pfd_edge_rise u_ref_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ref_pulse),
        .rise  (ref_rise)
    );

    pfd_edge_rise u_fb_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (fb_pulse),
        .rise  (fb_rise)
    );

    pfd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ref_rise (ref_rise),
        .fb_rise  (fb_rise),
        .state    (ph_state),
        .cyc_end  (cyc_end)
    );

    pfd_width_timer #(
        .WIDTH_LIMIT (WIDTH_LIMIT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (ph_state),
        .too_long (too_long)
    );

    pfd_lock_qual #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cyc_end  (cyc_end),
        .too_long (too_long),
        .locked   (locked)
    );

    // one drive decoder per filter output
    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
        pfd_pump_drive u_drv (
            .run   (run),
            .state (ph_state),
            .drv   (drv_q[g])
        );
    end

    assign pas_oe  = drv_q[PAS_IDX].oe;
    assign pas_lvl = drv_q[PAS_IDX].lvl;
    assign act_oe  = drv_q[ACT_IDX].oe;
    assign act_lvl = drv_q[ACT_IDX].lvl;

endmodule

// File: rtl/phase_lock_cmp_chk.sv
module phase_lock_cmp_chk
    import pfd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      run,
    input logic      pas_oe,
    input logic      pas_lvl,
    input logic      act_oe,
    input logic      act_lvl,
    input logic      locked,
    input ph_state_e state,
    input logic      ref_rise,
    input logic      fb_rise,
    input logic      cyc_end,
    input logic      too_long
);

    p_pair_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pas_oe == act_oe) && (pas_lvl == act_lvl));

    p_float_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pas_oe |-> !pas_lvl);

    p_ref_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == PH_IDLE && ref_rise && !fb_rise) |=> (!run || (pas_oe && pas_lvl)));

    p_fb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == PH_IDLE && fb_rise && !ref_rise) |=> (!run || (pas_oe && !pas_lvl)));

    p_up_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == PH_UP && fb_rise) |=> !pas_oe);

    p_dn_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == PH_DN && ref_rise) |=> !pas_oe);

    p_both_edges_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == PH_IDLE && ref_rise && fb_rise) |=> !pas_oe);

    p_float_standby_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pas_oe && !act_oe));

    p_lock_after_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(cyc_end));

    p_wide_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        too_long |=> !locked);

    p_standby_unlock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !locked);

endmodule

bind phase_lock_cmp phase_lock_cmp_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pas_oe   (pas_oe),
    .pas_lvl  (pas_lvl),
    .act_oe   (act_oe),
    .act_lvl  (act_lvl),
    .locked   (locked),
    .state    (ph_state),
    .ref_rise (ref_rise),
    .fb_rise  (fb_rise),
    .cyc_end  (cyc_end),
    .too_long (too_long)
);

// File: tb/phase_lock_cmp_bench.sv
`timescale 1ns/1ps
module phase_lock_cmp_bench;

    localparam int unsigned LIM = 6;
    localparam int unsigned NLK = 3;
    localparam int unsigned NV  = 20;

    // {run, ref, fb, exp_oe, exp_lvl, exp_locked}
    localparam logic [5:0] VEC [0:NV-1] = '{
        6'b110_110, 6'b110_110, 6'b101_000, 6'b100_000, 6'b101_100,
        6'b111_000, 6'b100_000, 6'b111_001, 6'b100_001, 6'b110_111,
        6'b100_111, 6'b110_111, 6'b101_001, 6'b000_000, 6'b110_110,
        6'b010_000, 6'b001_000, 6'b101_000, 6'b100_000, 6'b110_110
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic ref_pulse = 1'b0;
    logic fb_pulse = 1'b0;
    logic pas_oe, pas_lvl, act_oe, act_lvl, locked;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phase_lock_cmp #(
        .WIDTH_LIMIT (LIM),
        .LOCK_CYCLES (NLK)
    ) u_phase_lock_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .pas_oe    (pas_oe),
        .pas_lvl   (pas_lvl),
        .act_oe    (act_oe),
        .act_lvl   (act_lvl),
        .locked    (locked)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // drive one sample, let one edge pass, settle away from the edge
    task automatic step(input logic r, input logic rf, input logic fb);
        run = r;
        ref_pulse = rf;
        fb_pulse = fb;
        @(posedge clk);
        #1;
    endtask

    task automatic good_cycle();
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        run = 1'b0;
        ref_pulse = 1'b0;
        fb_pulse = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        chk("R1 reset pas_oe", pas_oe, 1'b0);
        chk("R1 reset pas_lvl", pas_lvl, 1'b0);
        chk("R1 reset act_oe", act_oe, 1'b0);
        chk("R1 reset locked", locked, 1'b0);

        // edge ordering and standby table (R2 R3 R4 R5 R6 R7 R11)
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3]);
            chk($sformatf("table %0d R2 R3 R4 R5 R6 R11 pas_oe", i), pas_oe, VEC[i][2]);
            chk($sformatf("table %0d R2 pas_lvl", i), pas_lvl, VEC[i][1]);
            chk($sformatf("table %0d R2 act_oe", i), act_oe, VEC[i][2]);
            chk($sformatf("table %0d R2 act_lvl", i), act_lvl, VEC[i][1]);
            chk($sformatf("table %0d R7 R10 locked", i), locked, VEC[i][0]);
        end

        // lock acquisition count
        do_reset();
        good_cycle();
        good_cycle();
        chk("R7 not locked after N-1 cycles", locked, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        chk("R7 locked at end of N-th cycle", locked, 1'b1);
        step(1'b1, 1'b0, 1'b0);

        // pulse of exactly the limit keeps lock
        step(1'b1, 1'b1, 1'b0);
        for (int k = 1; k < LIM; k++) step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        chk("R8 limit-width pulse ended", pas_oe, 1'b0);
        chk("R8 limit-width pulse keeps lock", locked, 1'b1);
        step(1'b1, 1'b0, 1'b0);

        // pulse one clock over the limit
        step(1'b1, 1'b1, 1'b0);
        for (int k = 1; k <= LIM; k++) step(1'b1, 1'b0, 1'b0);
        chk("R8 lock held until flag registers", locked, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        chk("R8 over-long pulse drops lock", locked, 1'b0);
        chk("R8 pump keeps running", pas_oe & pas_lvl, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        chk("R4 over-long pulse cleared by feedback", pas_oe, 1'b0);
        step(1'b1, 1'b0, 1'b0);

        // recount after a bad cycle
        good_cycle();
        good_cycle();
        chk("R9 still unlocked after N-1 good cycles", locked, 1'b0);
        good_cycle();
        chk("R9 relocked after N good cycles", locked, 1'b1);

        // standby clears lock and count
        step(1'b0, 1'b0, 1'b0);
        chk("R10 standby clears lock", locked, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        good_cycle();
        good_cycle();
        chk("R10 count restarted after standby", locked, 1'b0);
        good_cycle();
        chk("R10 relocked after N good cycles", locked, 1'b1);

        // held high level does not retrigger
        step(1'b1, 1'b0, 1'b1);
        chk("R3 lone feedback edge pumps down", pas_oe & ~pas_lvl, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        chk("R11 held feedback gives no edge, reference clears", pas_oe, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        chk("R11 held levels stay idle", pas_oe, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule